// File: doc/BRIEF.md
# Programmable Logic Array with Crosspoint Fault Injection

This block is a two-level programmable logic array. A set of product terms is formed from the true and complemented forms of the inputs, and each output is the logical OR of the product terms assigned to it. The connection pattern of both planes is held in registers and loaded one product-term row at a time through a configuration write port.

A separate fault-injection port picks a single crosspoint and one of four connection faults. A literal link in the first plane can be removed, which widens the term, or added, which narrows it. A term-to-output link in the second plane can be removed or added. The fault acts on the effective connection pattern only. The stored pattern is untouched, so clearing the fault restores fault-free behaviour at once. The outputs are purely combinational from the inputs and the effective pattern. This makes the block usable as a live fault model in functional test experiments.

Top module: `pla_fault_top`

## Requirements
- R1: After reset every stored crosspoint is unconnected, so every output is 0 for any input.
- R2: Writing with `cfgPlane`=0 loads row `cfgRow` of the literal plane from `cfgData[2*NUM_IN-1:0]`. Bit 2*i links the true form of input i and bit 2*i+1 links its complement. A product term is the AND of its linked literals, and a term with no linked literal is 1.
- R3: Writing with `cfgPlane`=1 loads row `cfgRow` of the sum plane from `cfgData[NUM_OUT-1:0]`. Bit o links that term to output o. Each output is the OR of its linked terms, and an output with no linked term is 0.
- R4: A product term whose effective links include both forms of the same input is 0 for every input.
- R5: With `faultEn`=1 and `faultKind`=0 (growth), literal-plane bit `faultCol` of term `faultRow` is treated as unlinked.
- R6: With `faultKind`=1 (shrinkage), literal-plane bit `faultCol` of term `faultRow` is treated as linked.
- R7: With `faultKind`=2 (disappearance), sum-plane bit `faultCol` of term `faultRow` is treated as unlinked.
- R8: With `faultKind`=3 (appearance), sum-plane bit `faultCol` of term `faultRow` is treated as linked.
- R9: At most one crosspoint differs between the effective and stored patterns. Injection never alters the stored pattern, so outputs return to fault-free values as soon as `faultEn` falls.
- R10: A fault that removes an already unlinked crosspoint, or adds an already linked one, leaves every output unchanged.
- R11: The following are ignored: a configuration write whose row is not below NUM_TERMS, and a fault whose row is not below NUM_TERMS or whose column is not below the width of the plane it targets (2*NUM_IN or NUM_OUT).
- R12: Outputs follow input changes combinationally, with no clock edge required.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration writes |
| rstN | input | 1 | Asynchronous active-low reset; clears the stored pattern |
| cfgWe | input | 1 | Configuration write strobe |
| cfgPlane | input | 1 | 0 selects the literal plane, 1 the sum plane |
| cfgRow | input | TW | Product-term row being written |
| cfgData | input | DW | Row contents |
| faultEn | input | 1 | Enables the injected fault |
| faultKind | input | 2 | 0 growth, 1 shrinkage, 2 disappearance, 3 appearance |
| faultRow | input | TW | Product term holding the faulty crosspoint |
| faultCol | input | CW | Literal bit or output index of the crosspoint |
| dIn | input | NUM_IN | Array inputs |
| dOut | output | NUM_OUT | Array outputs |

## Verification
A corrupted literal-plane bit shows up only as a wrong output value. It appears for the input patterns that make that term decide an output, and it appears in the same cycle as those inputs, because the evaluation path holds no register. A corrupted sum-plane bit appears as an output stuck high whenever the wrongly linked term is true, or as missing ones when a link is lost. Random personalities are therefore paired with many random input vectors between writes, and each fault is compared with the fault-free value before and after it is applied. This catches both wrong fault effects and any fault that leaks into storage.

// File: rtl/pla_pkg.sv
package pla_pkg;

  typedef enum logic [1:0] {
    FLT_GROW   = 2'd0,
    FLT_SHRINK = 2'd1,
    FLT_VANISH = 2'd2,
    FLT_APPEAR = 2'd3
  } fault_kind_e;

  typedef struct packed {
    logic andWr;
    logic orWr;
    logic andDrop;
    logic andAdd;
    logic orDrop;
    logic orAdd;
  } pla_strobe_t;

endpackage

// File: rtl/pla_ctrl.sv
module pla_ctrl
  import pla_pkg::*;
#(
  parameter int NUM_IN    = 4,
  parameter int NUM_TERMS = 6,
  parameter int NUM_OUT   = 3,
  parameter int TW        = 3,
  parameter int CW        = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgWe,
  input  logic          cfgPlane,
  input  logic [TW-1:0] cfgRow,
  input  logic          faultEn,
  input  logic [1:0]    faultKind,
  input  logic [TW-1:0] faultRow,
  input  logic [CW-1:0] faultCol,
  output pla_strobe_t   strb
);

  localparam int LW = 2 * NUM_IN;

  logic cfgRowOk;
  logic fltRowOk;
  logic fltAndColOk;
  logic fltOrColOk;

  always_comb begin
    cfgRowOk    = int'(cfgRow) < NUM_TERMS;
    fltRowOk    = int'(faultRow) < NUM_TERMS;
    fltAndColOk = int'(faultCol) < LW;
    fltOrColOk  = int'(faultCol) < NUM_OUT;

    strb       = '0;
    strb.andWr = cfgWe && !cfgPlane && cfgRowOk;
    strb.orWr  = cfgWe && cfgPlane && cfgRowOk;

    if (faultEn && fltRowOk) begin
      case (fault_kind_e'(faultKind))
        FLT_GROW:   strb.andDrop = fltAndColOk;
        FLT_SHRINK: strb.andAdd  = fltAndColOk;
        FLT_VANISH: strb.orDrop  = fltOrColOk;
        FLT_APPEAR: strb.orAdd   = fltOrColOk;
        default:    ;
      endcase
    end
  end

  // R9
  single_fault_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.andDrop, strb.andAdd, strb.orDrop, strb.orAdd}));

  // R11
  row_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.andWr || strb.orWr) |-> (int'(cfgRow) < NUM_TERMS));

endmodule

// File: rtl/pla_datapath.sv
module pla_datapath
  import pla_pkg::*;
#(
  parameter int NUM_IN    = 4,
  parameter int NUM_TERMS = 6,
  parameter int NUM_OUT   = 3,
  parameter int TW        = 3,
  parameter int CW        = 3,
  parameter int DW        = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  pla_strobe_t        strb,
  input  logic [TW-1:0]      cfgRow,
  input  logic [DW-1:0]      cfgData,
  input  logic [TW-1:0]      faultRow,
  input  logic [CW-1:0]      faultCol,
  input  logic [NUM_IN-1:0]  dIn,
  output logic [NUM_OUT-1:0] dOut
);

  localparam int LW = 2 * NUM_IN;

  logic [NUM_TERMS-1:0][LW-1:0]      andMem;
  logic [NUM_TERMS-1:0][NUM_OUT-1:0] orMem;
  logic [NUM_TERMS-1:0][LW-1:0]      effAnd;
  logic [NUM_TERMS-1:0][NUM_OUT-1:0] effOr;
  logic [LW-1:0]                     lits;
  logic [NUM_TERMS-1:0]              termVal;
  logic [NUM_TERMS-1:0]              termClash;
  logic [NUM_OUT-1:0][NUM_TERMS-1:0] colLinks;

  // Personality storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      andMem <= '0;
      orMem  <= '0;
    end else begin
      for (int p = 0; p < NUM_TERMS; p++) begin
        if (cfgRow == TW'(p)) begin
          if (strb.andWr) andMem[p] <= cfgData[LW-1:0];
          if (strb.orWr)  orMem[p]  <= cfgData[NUM_OUT-1:0];
        end
      end
    end
  end

  // Effective pattern: stored pattern with at most one crosspoint overridden
  always_comb begin
    effAnd = andMem;
    effOr  = orMem;
    for (int p = 0; p < NUM_TERMS; p++) begin
      for (int b = 0; b < LW; b++) begin
        if (faultRow == TW'(p) && faultCol == CW'(b)) begin
          if (strb.andDrop) effAnd[p][b] = 1'b0;
          if (strb.andAdd)  effAnd[p][b] = 1'b1;
        end
      end
      for (int o = 0; o < NUM_OUT; o++) begin
        if (faultRow == TW'(p) && faultCol == CW'(o)) begin
          if (strb.orDrop) effOr[p][o] = 1'b0;
          if (strb.orAdd)  effOr[p][o] = 1'b1;
        end
      end
    end
  end

  // Literal rails: even bit true form, odd bit complement
  genvar gi, gp;
  generate
    for (gi = 0; gi < NUM_IN; gi++) begin : g_lit
      assign lits[2*gi]   = dIn[gi];
      assign lits[2*gi+1] = ~dIn[gi];
    end

    for (gp = 0; gp < NUM_TERMS; gp++) begin : g_term
      logic [NUM_IN-1:0] pairHit;
      for (gi = 0; gi < NUM_IN; gi++) begin : g_pair
        assign pairHit[gi] = effAnd[gp][2*gi] & effAnd[gp][2*gi+1];
      end
      assign termClash[gp] = |pairHit;
      assign termVal[gp]   = &(~effAnd[gp] | lits);

      // R4
      clash_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
        termClash[gp] |-> !termVal[gp]);
    end
  endgenerate

  // Sum plane
  always_comb begin
    for (int o = 0; o < NUM_OUT; o++) begin
      for (int p = 0; p < NUM_TERMS; p++) begin
        colLinks[o][p] = effOr[p][o];
      end
      dOut[o] = |(colLinks[o] & termVal);
    end
  end

  genvar go;
  generate
    for (go = 0; go < NUM_OUT; go++) begin : g_out
      // R3
      empty_col_chk: assert property (@(posedge clk) disable iff (!rstN)
        !(|colLinks[go]) |-> !dOut[go]);
    end
  endgenerate

  // R9
  one_point_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(andMem ^ effAnd) + $countones(orMem ^ effOr)) <= 1);

  // R9
  store_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.andWr || strb.orWr) |=> ($stable(andMem) && $stable(orMem)));

endmodule

// File: rtl/pla_fault_top.sv
module pla_fault_top
  import pla_pkg::*;
#(
  parameter int NUM_IN    = 4,
  parameter int NUM_TERMS = 6,
  parameter int NUM_OUT   = 3,
  localparam int LW       = 2 * NUM_IN,
  localparam int DW       = (LW > NUM_OUT) ? LW : NUM_OUT,
  localparam int TW       = $clog2((NUM_TERMS > 1) ? NUM_TERMS : 2),
  localparam int CW       = $clog2((DW > 1) ? DW : 2)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWe,
  input  logic               cfgPlane,
  input  logic [TW-1:0]      cfgRow,
  input  logic [DW-1:0]      cfgData,
  input  logic               faultEn,
  input  logic [1:0]         faultKind,
  input  logic [TW-1:0]      faultRow,
  input  logic [CW-1:0]      faultCol,
  input  logic [NUM_IN-1:0]  dIn,
  output logic [NUM_OUT-1:0] dOut
);

  pla_strobe_t strb;

  pla_ctrl #(
    .NUM_IN(NUM_IN), .NUM_TERMS(NUM_TERMS), .NUM_OUT(NUM_OUT), .TW(TW), .CW(CW)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgPlane(cfgPlane), .cfgRow(cfgRow),
    .faultEn(faultEn), .faultKind(faultKind), .faultRow(faultRow),
    .faultCol(faultCol), .strb(strb)
  );

  pla_datapath #(
    .NUM_IN(NUM_IN), .NUM_TERMS(NUM_TERMS), .NUM_OUT(NUM_OUT),
    .TW(TW), .CW(CW), .DW(DW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgRow(cfgRow), .cfgData(cfgData),
    .faultRow(faultRow), .faultCol(faultCol), .dIn(dIn), .dOut(dOut)
  );

endmodule

// File: tb/sim_pla_fault_top.sv
module sim_pla_fault_top;

  localparam int NI = 4;
  localparam int NP = 6;
  localparam int NO = 3;
  localparam int LW = 2 * NI;
  localparam int DW = (LW > NO) ? LW : NO;
  localparam int TW = $clog2(NP);
  localparam int CW = $clog2(DW);
  localparam int CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rstN;
  logic          cfgWe;
  logic          cfgPlane;
  logic [TW-1:0] cfgRow;
  logic [DW-1:0] cfgData;
  logic          faultEn;
  logic [1:0]    faultKind;
  logic [TW-1:0] faultRow;
  logic [CW-1:0] faultCol;
  logic [NI-1:0] dIn;
  logic [NO-1:0] dOut;

  int testsRun = 0;
  int testsFailed = 0;

  logic [NP-1:0][LW-1:0] mAnd;
  logic [NP-1:0][NO-1:0] mOr;

  always #(CLK_PERIOD/2) clk = ~clk;

  pla_fault_top #(.NUM_IN(NI), .NUM_TERMS(NP), .NUM_OUT(NO)) u0 (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgPlane(cfgPlane), .cfgRow(cfgRow),
    .cfgData(cfgData), .faultEn(faultEn), .faultKind(faultKind),
    .faultRow(faultRow), .faultCol(faultCol), .dIn(dIn), .dOut(dOut)
  );

  function automatic logic [NO-1:0] expOut(logic [NI-1:0] x, logic en,
                                           logic [1:0] k, int r, int c);
    logic [NP-1:0][LW-1:0] a;
    logic [NP-1:0][NO-1:0] q;
    logic [NO-1:0] y;
    logic t;
    a = mAnd;
    q = mOr;
    if (en && r < NP) begin
      if (k == 2'd0 && c < LW) a[r][c] = 1'b0;
      if (k == 2'd1 && c < LW) a[r][c] = 1'b1;
      if (k == 2'd2 && c < NO) q[r][c] = 1'b0;
      if (k == 2'd3 && c < NO) q[r][c] = 1'b1;
    end
    y = '0;
    for (int p = 0; p < NP; p++) begin
      t = 1'b1;
      for (int i = 0; i < NI; i++) begin
        if (a[p][2*i] && !x[i]) t = 1'b0;
        if (a[p][2*i+1] && x[i]) t = 1'b0;
      end
      for (int o = 0; o < NO; o++) if (t && q[p][o]) y[o] = 1'b1;
    end
    return y;
  endfunction

  task automatic cfgWrite(logic plane, int row, logic [DW-1:0] data);
    @(negedge clk);
    cfgWe = 1'b1; cfgPlane = plane; cfgRow = TW'(row); cfgData = data;
    @(posedge clk);
    @(negedge clk);
    cfgWe = 1'b0;
    if (row < NP) begin
      if (!plane) mAnd[row] = data[LW-1:0];
      else        mOr[row]  = data[NO-1:0];
    end
  endtask

  task automatic probe(logic [NI-1:0] x, logic en, logic [1:0] k, int r, int c,
                       string tag);
    logic [NO-1:0] e;
    @(negedge clk);
    dIn = x; faultEn = en; faultKind = k; faultRow = TW'(r); faultCol = CW'(c);
    #1;
    e = expOut(x, en, k, r, c);
    testsRun++;
    if (dOut !== e) begin
      testsFailed++;
      $display("FAIL %s: in=%b fault=%b kind=%0d row=%0d col=%0d got %b expected %b",
               tag, x, en, k, r, c, dOut, e);
    end
  endtask

  task automatic probeFixed(logic [NI-1:0] x, logic en, logic [1:0] k, int r, int c,
                            logic [NO-1:0] want, string tag);
    @(negedge clk);
    dIn = x; faultEn = en; faultKind = k; faultRow = TW'(r); faultCol = CW'(c);
    #1;
    testsRun++;
    if (dOut !== want) begin
      testsFailed++;
      $display("FAIL %s: got %b expected %b", tag, dOut, want);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    testsFailed++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    mAnd = '0; mOr = '0;
    rstN = 1'b0; cfgWe = 1'b0; cfgPlane = 1'b0; cfgRow = '0; cfgData = '0;
    faultEn = 1'b0; faultKind = '0; faultRow = '0; faultCol = '0; dIn = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    probeFixed(4'b0000, 1'b0, 2'd0, 0, 0, 3'b000, "R1 reset in=0");
    probeFixed(4'b1111, 1'b0, 2'd0, 0, 0, 3'b000, "R1 reset in=F");

    // R2/R3 empty term is 1, routed to out0
    cfgWrite(1'b1, 0, 8'h01);
    probeFixed(4'b1010, 1'b0, 2'd0, 0, 0, 3'b001, "R2 empty term true");
    // R2 single true literal of input 0
    cfgWrite(1'b0, 0, 8'h01);
    probeFixed(4'b0000, 1'b0, 2'd0, 0, 0, 3'b000, "R2 literal low");
    probeFixed(4'b0001, 1'b0, 2'd0, 0, 0, 3'b001, "R2 literal high");
    // R12 input change without clock edge
    probeFixed(4'b0000, 1'b0, 2'd0, 0, 0, 3'b000, "R12 combinational");
    // R4 both forms of input 0
    cfgWrite(1'b0, 0, 8'h03);
    probeFixed(4'b0000, 1'b0, 2'd0, 0, 0, 3'b000, "R4 clash in=0");
    probeFixed(4'b0001, 1'b0, 2'd0, 0, 0, 3'b000, "R4 clash in=1");
    // R5 growth: term = in0 & in1, drop in1 link (bit 2)
    cfgWrite(1'b0, 0, 8'h05);
    probeFixed(4'b0001, 1'b0, 2'd0, 0, 2, 3'b000, "R5 before growth");
    probeFixed(4'b0001, 1'b1, 2'd0, 0, 2, 3'b001, "R5 growth");
    // R9 revert after fault cleared
    probeFixed(4'b0001, 1'b0, 2'd0, 0, 2, 3'b000, "R9 revert");
    // R6 shrinkage: add complement of in1 (bit 3) to term in0
    cfgWrite(1'b0, 0, 8'h01);
    probeFixed(4'b0011, 1'b1, 2'd1, 0, 3, 3'b000, "R6 shrinkage");
    probeFixed(4'b0001, 1'b1, 2'd1, 0, 3, 3'b001, "R6 shrinkage pass");
    // R7 disappearance of term0 -> out0
    probeFixed(4'b0001, 1'b1, 2'd2, 0, 0, 3'b000, "R7 disappearance");
    // R8 appearance: term1 (empty, =1) onto out1
    probeFixed(4'b0000, 1'b1, 2'd3, 1, 1, 3'b010, "R8 appearance");
    // R10 no-effect faults
    probeFixed(4'b0001, 1'b1, 2'd1, 0, 0, 3'b001, "R10 add existing");
    probeFixed(4'b0001, 1'b1, 2'd0, 0, 5, 3'b001, "R10 drop absent");
    probeFixed(4'b0001, 1'b1, 2'd3, 0, 0, 3'b001, "R10 appear existing");
    // R11 out-of-range write and fault
    cfgWrite(1'b1, 6, 8'hFF);
    cfgWrite(1'b0, 7, 8'hFF);
    probeFixed(4'b0001, 1'b0, 2'd0, 0, 0, 3'b001, "R11 row write ignored");
    probeFixed(4'b0000, 1'b1, 2'd3, 1, 5, 3'b000, "R11 column ignored");
    probeFixed(4'b0000, 1'b1, 2'd3, 7, 0, 3'b000, "R11 fault row ignored");

    // Random mix: R2 R3 R4 R5 R6 R7 R8 R9 R10 R11
    for (int n = 0; n < 600; n++) begin
      int op;
      op = int'($urandom % 5);
      if (op == 0) begin
        logic [DW-1:0] d;
        d = DW'($urandom);
        if (($urandom % 3) != 0) for (int i = 0; i < NI; i++)
          if (d[2*i] && d[2*i+1]) d[2*i+($urandom%2)] = 1'b0;
        cfgWrite(1'b0, int'($urandom % 8), d);
      end else if (op == 1) begin
        cfgWrite(1'b1, int'($urandom % 8), DW'($urandom));
      end else begin
        probe(NI'($urandom), 1'($urandom), 2'($urandom), int'($urandom % 8),
              int'($urandom % 8), "R5-R9 random fault");
        probe(dIn, 1'b0, 2'd0, 0, 0, "R9 random fault-free");
      end
    end

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule